// File: doc/BRIEF.md
# Byte Command Controller for a 2x2 Matrix Engine

This block turns a stream of received bytes into actions on a small matrix engine and sends result bytes back. It sits between a byte-wide serial receiver and transmitter, which it sees as plain byte ports, and the engine, which it sees as two staging registers, a start strobe, two result words and a state nibble. The first byte of each command is an opcode. Depending on the opcode, the block collects four payload bytes into the weight or activation staging register, fires the start strobe, or returns a response of one or four bytes.

The serial link runs at 115200 baud with 8 data bits, no parity and one stop bit. At that rate a byte arrives at most once every several thousand clock cycles, so the receive port has no back-pressure. The transmit port has a valid/ready handshake so that the serializer can pace the response. Each staging register holds four elements of a 2x2 matrix. Element index i (0 = row0/col0, 1 = row0/col1, 2 = row1/col0, 3 = row1/col1) occupies bits [8i+7:8i].

Top module: `cmd_byte_ctrl`

## Requirements
- R1: Opcode 0x01 followed by four bytes loads the weight staging output `wt_flat`. The bytes arrive in the order element 0, 1, 2, 3, and element i lands in bits [8i+7:8i].
- R2: A staging output changes only in the cycle after its fourth payload byte is accepted. After three payload bytes it still holds its previous value.
- R3: Opcode 0x02 followed by four bytes loads `act_flat` with the same byte order and bit placement as R1.
- R4: Opcode 0x04 returns the four bytes of `col0_res` and opcode 0x05 returns the four bytes of `col1_res`. The word is sampled in the cycle the opcode is accepted and sent most significant byte first.
- R5: Opcode 0x03 takes no payload. It drives `go_pulse` high for exactly the one cycle after the opcode is accepted.
- R6: Opcode 0x06 returns one byte. Bits [7:4] hold `eng_state` and bits [3:0] hold a counter of cycles since the last accepted 0x03. The counter is 0 when 0x06 immediately follows 0x03, stops at 15, and is 0 after reset.
- R7: Any other opcode value (0x00 or 0x07 to 0xFF) is discarded, and the next byte is again decoded as an opcode.
- R8: While `tx_valid` is high and `tx_ready` is low, `tx_valid` and `tx_data` hold. Each later byte appears only after the previous one is accepted, and `tx_valid` drops after the last byte.
- R9: Bytes received while a response is pending are ignored. They cause no write, no start strobe and no new command.
- R10: After reset, `tx_valid` and `go_pulse` are low and both staging outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | One-cycle strobe marking a received byte |
| tx_data | output | 8 | Response byte to the transmitter |
| tx_valid | output | 1 | Response byte available |
| tx_ready | input | 1 | Transmitter takes the byte in this cycle |
| wt_flat | output | 32 | Weight staging register, four elements |
| act_flat | output | 32 | Activation staging register, four elements |
| go_pulse | output | 1 | One-cycle start strobe to the engine |
| col0_res | input | 32 | Engine result for column 0 |
| col1_res | input | 32 | Engine result for column 1 |
| eng_state | input | 4 | Engine state reported in the status byte |

## Verification
Every result is due one register stage after the byte that causes it:

- A staging update shows in the cycle after the fourth payload byte.
- The start strobe shows in the cycle after the 0x03 opcode.
- The first response byte is valid in the cycle after the read opcode.
- Each later response byte appears in the cycle after the previous one is taken.

The bench drives inputs and samples outputs on the falling edge, so each check falls exactly one rising edge after its stimulus. Hold behaviour is checked by stalling `tx_ready` for a cycle and comparing again. The status counter's expected value is the number of falling-edge waits the bench itself inserts between the 0x03 and 0x06 opcodes.

// File: rtl/cmd_pkg.sv
package cmd_pkg;
  typedef enum logic [1:0] {
    PS_IDLE    = 2'd0,
    PS_PAYLOAD = 2'd1,
    PS_RESP    = 2'd2
  } ps_e;

  localparam logic [7:0] OP_WT   = 8'h01;
  localparam logic [7:0] OP_ACT  = 8'h02;
  localparam logic [7:0] OP_GO   = 8'h03;
  localparam logic [7:0] OP_RD0  = 8'h04;
  localparam logic [7:0] OP_RD1  = 8'h05;
  localparam logic [7:0] OP_STAT = 8'h06;
endpackage

// File: rtl/cmd_stage_reg.sv
module cmd_stage_reg #(
  parameter int BYTE_W = 8,
  parameter int ELEMS  = 4,
  localparam int IDX_W = $clog2(ELEMS),
  localparam int OUT_W = BYTE_W * ELEMS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [BYTE_W-1:0] wr_byte,
  output logic [OUT_W-1:0]  q
);
  localparam int SH_W = BYTE_W * (ELEMS - 1);

  logic [SH_W-1:0] shadow_q;
  logic            last_w;

  assign last_w = wr_en && (wr_idx == IDX_W'(ELEMS - 1));

  // Early elements wait here so the engine never sees a half-written matrix.
  for (genvar e = 0; e < ELEMS - 1; e++) begin : g_shadow
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shadow_q[e*BYTE_W +: BYTE_W] <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(e))) begin
        shadow_q[e*BYTE_W +: BYTE_W] <= wr_byte;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (last_w) begin
      q <= {wr_byte, shadow_q};
    end
  end
endmodule

// File: rtl/cmd_resp_ser.sv
module cmd_resp_ser #(
  parameter int BYTE_W = 8,
  parameter int RES_W  = 32,
  localparam int NBYTES = RES_W / BYTE_W,
  localparam int LEN_W  = $clog2(NBYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [RES_W-1:0]  load_word,
  input  logic [LEN_W-1:0]  load_len,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  output logic              last_take
);
  logic [RES_W-1:0] sh_q;
  logic [LEN_W-1:0] rem_q;
  logic             take_w;

  assign tx_valid  = (rem_q != '0);
  assign tx_data   = sh_q[RES_W-1 -: BYTE_W];
  assign take_w    = tx_valid && tx_ready;
  assign last_take = take_w && (rem_q == LEN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      rem_q <= '0;
    end else if (load) begin
      sh_q  <= load_word;
      rem_q <= load_len;
    end else if (take_w) begin
      sh_q  <= sh_q << BYTE_W;
      rem_q <= rem_q - LEN_W'(1);
    end
  end
endmodule

// File: rtl/cmd_cyc_cnt.sv
module cmd_cyc_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  output logic [CNT_W-1:0] value
);
  logic sat_w;

  assign sat_w = &value;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value <= '0;
    end else if (clr) begin
      value <= '0;
    end else if (!sat_w) begin
      value <= value + CNT_W'(1);
    end
  end
endmodule

// File: rtl/cmd_byte_ctrl.sv
module cmd_byte_ctrl #(
  parameter int BYTE_W = 8,
  parameter int ELEMS  = 4,
  parameter int RES_W  = 32,
  parameter int CNT_W  = 4,
  localparam int MAT_W  = BYTE_W * ELEMS,
  localparam int IDX_W  = $clog2(ELEMS),
  localparam int NBYTES = RES_W / BYTE_W,
  localparam int LEN_W  = $clog2(NBYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              rx_valid,
  output logic [BYTE_W-1:0] tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [MAT_W-1:0]  wt_flat,
  output logic [MAT_W-1:0]  act_flat,
  output logic              go_pulse,
  input  logic [RES_W-1:0]  col0_res,
  input  logic [RES_W-1:0]  col1_res,
  input  logic [CNT_W-1:0]  eng_state
);
  import cmd_pkg::*;

  ps_e              state_q, state_d;
  logic             kind_q, kind_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             go_d;
  logic             ld_w;
  logic [RES_W-1:0] ld_word_w;
  logic [LEN_W-1:0] ld_len_w;
  logic             wt_we_w, act_we_w;
  logic             last_take_w;
  logic [CNT_W-1:0] cyc_w;

  always_comb begin
    state_d   = state_q;
    kind_d    = kind_q;
    idx_d     = idx_q;
    go_d      = 1'b0;
    ld_w      = 1'b0;
    ld_word_w = '0;
    ld_len_w  = '0;
    wt_we_w   = 1'b0;
    act_we_w  = 1'b0;
    unique case (state_q)
      PS_IDLE: begin
        if (rx_valid) begin
          case (rx_data)
            OP_WT:  begin state_d = PS_PAYLOAD; kind_d = 1'b0; idx_d = '0; end
            OP_ACT: begin state_d = PS_PAYLOAD; kind_d = 1'b1; idx_d = '0; end
            OP_GO:  go_d = 1'b1;
            OP_RD0: begin
              ld_w = 1'b1; ld_word_w = col0_res; ld_len_w = LEN_W'(NBYTES);
              state_d = PS_RESP;
            end
            OP_RD1: begin
              ld_w = 1'b1; ld_word_w = col1_res; ld_len_w = LEN_W'(NBYTES);
              state_d = PS_RESP;
            end
            OP_STAT: begin
              ld_w = 1'b1;
              ld_word_w = {eng_state, cyc_w, {(RES_W - 2*CNT_W){1'b0}}};
              ld_len_w = LEN_W'(1);
              state_d = PS_RESP;
            end
            default: ;
          endcase
        end
      end
      PS_PAYLOAD: begin
        if (rx_valid) begin
          wt_we_w  = !kind_q;
          act_we_w = kind_q;
          idx_d    = idx_q + IDX_W'(1);
          if (idx_q == IDX_W'(ELEMS - 1)) state_d = PS_IDLE;
        end
      end
      PS_RESP: begin
        if (last_take_w) state_d = PS_IDLE;
      end
      default: state_d = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= PS_IDLE;
      kind_q   <= 1'b0;
      idx_q    <= '0;
      go_pulse <= 1'b0;
    end else begin
      state_q  <= state_d;
      kind_q   <= kind_d;
      idx_q    <= idx_d;
      go_pulse <= go_d;
    end
  end

  cmd_stage_reg #(.BYTE_W(BYTE_W), .ELEMS(ELEMS)) wt_stage_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wt_we_w), .wr_idx(idx_q),
    .wr_byte(rx_data), .q(wt_flat)
  );

  cmd_stage_reg #(.BYTE_W(BYTE_W), .ELEMS(ELEMS)) act_stage_i (
    .clk(clk), .rst_n(rst_n), .wr_en(act_we_w), .wr_idx(idx_q),
    .wr_byte(rx_data), .q(act_flat)
  );

  cmd_resp_ser #(.BYTE_W(BYTE_W), .RES_W(RES_W)) ser_i (
    .clk(clk), .rst_n(rst_n), .load(ld_w), .load_word(ld_word_w),
    .load_len(ld_len_w), .tx_ready(tx_ready), .tx_valid(tx_valid),
    .tx_data(tx_data), .last_take(last_take_w)
  );

  cmd_cyc_cnt #(.CNT_W(CNT_W)) cyc_i (
    .clk(clk), .rst_n(rst_n), .clr(go_d), .value(cyc_w)
  );
endmodule

// File: rtl/cmd_byte_ctrl_chk.sv
module cmd_byte_ctrl_chk #(
  parameter int BYTE_W = 8,
  parameter int MAT_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_valid,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [BYTE_W-1:0] tx_data,
  input logic              go_pulse,
  input logic [MAT_W-1:0]  wt_flat,
  input logic [MAT_W-1:0]  act_flat
);
  // R2: staging outputs only move right after a received byte
  a_r2_wt_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wt_flat) |-> $past(rx_valid));
  a_r2_act_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_flat) |-> $past(rx_valid));
  // R5: start strobe lasts one cycle
  a_r5_go_single: assert property (@(posedge clk) disable iff (!rst_n)
    go_pulse |=> !go_pulse);
  // R8: byte held while stalled
  a_r8_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
  // R9: nothing happens from input while a response is pending
  a_r9_rx_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |=> (!go_pulse && $stable(wt_flat) && $stable(act_flat)));
endmodule

bind cmd_byte_ctrl cmd_byte_ctrl_chk #(.BYTE_W(BYTE_W), .MAT_W(MAT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .tx_data(tx_data), .go_pulse(go_pulse),
  .wt_flat(wt_flat), .act_flat(act_flat)
);

// File: tb/cmd_byte_ctrl_tb_top.sv
`timescale 1ns/1ps
module cmd_byte_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_valid = 1'b0;
  logic [7:0]  tx_data;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic [31:0] wt_flat, act_flat;
  logic        go_pulse;
  logic [31:0] col0_res = '0, col1_res = '0;
  logic [3:0]  eng_state = '0;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  cmd_byte_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .wt_flat(wt_flat), .act_flat(act_flat), .go_pulse(go_pulse),
    .col0_res(col0_res), .col1_res(col1_res), .eng_state(eng_state)
  );

  // {opcode, payload or unused, col0, col1}
  localparam logic [103:0] VEC [7] = '{
    {8'h01, 32'h44332211, 32'h0, 32'h0},
    {8'h02, 32'h08070605, 32'h0, 32'h0},
    {8'h04, 32'h0, 32'hDEADBEEF, 32'h12345678},
    {8'h05, 32'h0, 32'h0BADF00D, 32'hCAFE0042},
    {8'h01, 32'hFF80007F, 32'h0, 32'h0},
    {8'h02, 32'h01FE02FD, 32'h0, 32'h0},
    {8'h04, 32'h0, 32'h80000001, 32'h0}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    rx_data  = b;
    rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic read_resp(input logic [31:0] word, input int len, input bit stall, input string tag);
    for (int i = 0; i < len; i++) begin
      logic [7:0] eb;
      eb = word[31 - 8*i -: 8];
      chk(tx_valid === 1'b1, {tag, " valid"}, {31'b0, tx_valid}, 32'h1);
      chk(tx_data === eb, {tag, " byte"}, {24'b0, tx_data}, {24'b0, eb});
      if (stall) begin
        @(negedge clk);
        chk(tx_valid === 1'b1 && tx_data === eb, "R8 hold while stalled", {24'b0, tx_data}, {24'b0, eb});
      end
      tx_ready = 1'b1;
      @(negedge clk);
      tx_ready = 1'b0;
    end
    chk(tx_valid === 1'b0, {tag, " end"}, {31'b0, tx_valid}, 32'h0);
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(tx_valid === 1'b0, "R10 tx_valid", {31'b0, tx_valid}, 0);
    chk(go_pulse === 1'b0, "R10 go_pulse", {31'b0, go_pulse}, 0);
    chk(wt_flat === 32'h0, "R10 wt_flat", wt_flat, 0);
    chk(act_flat === 32'h0, "R10 act_flat", act_flat, 0);

    // Table walk: R1, R2, R3, R4, R8
    for (int v = 0; v < 7; v++) begin
      logic [7:0]  op;
      logic [31:0] pay, prev;
      op  = VEC[v][103:96];
      pay = VEC[v][95:64];
      col0_res = VEC[v][63:32];
      col1_res = VEC[v][31:0];
      if (op == 8'h01 || op == 8'h02) begin
        prev = (op == 8'h01) ? wt_flat : act_flat;
        send_byte(op);
        for (int e = 0; e < 3; e++) send_byte(pay[8*e +: 8]);
        chk(((op == 8'h01) ? wt_flat : act_flat) === prev, "R2 no partial update",
            (op == 8'h01) ? wt_flat : act_flat, prev);
        send_byte(pay[31:24]);
        if (op == 8'h01) chk(wt_flat === pay, "R1 weight load", wt_flat, pay);
        else             chk(act_flat === pay, "R3 activation load", act_flat, pay);
      end else begin
        send_byte(op);
        col0_res = ~col0_res; // R4: value is sampled at opcode acceptance
        col1_res = ~col1_res;
        read_resp((op == 8'h04) ? VEC[v][63:32] : VEC[v][31:0], 4, op == 8'h05, "R4 result");
      end
    end

    // R5 start strobe
    eng_state = 4'hA;
    send_byte(8'h03);
    chk(go_pulse === 1'b1, "R5 go high", {31'b0, go_pulse}, 1);
    @(negedge clk);
    chk(go_pulse === 1'b0, "R5 go single", {31'b0, go_pulse}, 0);
    // R6 status: one wait since start
    send_byte(8'h06);
    read_resp(32'hA1000000, 1, 1'b0, "R6 status count 1");
    send_byte(8'h03);
    send_byte(8'h06);
    read_resp(32'hA0000000, 1, 1'b0, "R6 status count 0");
    eng_state = 4'h5;
    send_byte(8'h03);
    repeat (20) @(negedge clk);
    send_byte(8'h06);
    read_resp(32'h5F000000, 1, 1'b0, "R6 status saturate");

    // R7 unknown opcodes discarded
    col1_res = 32'h00C0FFEE;
    send_byte(8'h07);
    send_byte(8'h00);
    send_byte(8'hFF);
    chk(tx_valid === 1'b0 && go_pulse === 1'b0, "R7 no action", {31'b0, tx_valid}, 0);
    send_byte(8'h05);
    read_resp(32'h00C0FFEE, 4, 1'b0, "R7 next opcode decoded");

    // R9 bytes during a pending response
    begin
      logic [31:0] wprev;
      wprev = wt_flat;
      col0_res = 32'h13579BDF;
      send_byte(8'h04);
      send_byte(8'h01);
      send_byte(8'h03);
      chk(go_pulse === 1'b0, "R9 no start", {31'b0, go_pulse}, 0);
      read_resp(32'h13579BDF, 4, 1'b0, "R9 response intact");
      chk(wt_flat === wprev, "R9 weights untouched", wt_flat, wprev);
      eng_state = 4'h3;
      send_byte(8'h06);
      chk(tx_valid === 1'b1 && tx_data[7:4] === 4'h3, "R9 parser idle", {24'b0, tx_data}, 32'h30);
      tx_ready = 1'b1;
      @(negedge clk);
      tx_ready = 1'b0;
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule